// File: doc/BRIEF.md
# Raster Frame Timing Generator

This block produces the raster timing of a video frame. A dot-clock enable advances a dot counter within each scanline and a scanline counter within each frame. At a fixed position in the frame it raises a vertical-blank flag. That flag drives an interrupt-style output and can also be read through a one-bit status port. A status read hands the current flag value to the reader and clears the flag. Once each frame, the flag is cleared on its own at a second fixed position.

A frame-parity bit toggles every time the frame wraps. On frames of odd parity, while the rendering-enable input is high, the last scanline is cut short by one dot. The counter jumps from the skip dot straight to the origin of the next frame. Over many frames this gives a fractional average frame length when rendering is on, and a constant length when it is off.

The geometry is set by parameters: dots per line, lines per frame, the set and clear lines, the flag dot and the skip dot. A parameter also removes the odd-frame skip entirely. The default values describe a 341-dot by 262-line frame, with the flag set on line 241 and cleared on line 261.

Top module: `raster_timing_gen`

## Requirements
- R1: A synchronous active-high reset sets the dot counter, the line counter, the parity bit and the vertical-blank flag to zero, so the interrupt output is low.
- R2: On each clock with the dot enable high, the dot counter advances by one. From dot DOTS-1 it returns to 0 and the line counter advances. From line LINES-1 the line counter returns to 0. With the dot enable low, neither counter changes.
- R3: The parity bit inverts on every frame wrap, meaning every step that lands on line 0, dot 0. It holds at all other times.
- R4: When the parity bit is 1 and rendering-enable is 1 on the enabled step taken at line LINES-1, dot SKIP_DOT, the next position is line 0, dot 0. The frame then lasts DOTS*LINES-1 dots.
- R5: When the parity bit is 0, or rendering-enable is 0 at that step, no dot is skipped and the frame lasts DOTS*LINES dots.
- R6: The enabled step taken at line SET_LINE, dot FLAG_DOT sets the vertical-blank flag, unless a status read happens in the same cycle. The flag is visible from the next cycle.
- R7: The enabled step taken at line CLR_LINE, dot FLAG_DOT clears the flag, even if no read has occurred.
- R8: While the status read strobe is high, the status bit shows the flag. The flag is clear from the following cycle, so a second read right after the first returns 0.
- R9: A status read in the same cycle as the setting step of R6 returns 0, and the flag stays clear for the rest of that frame.
- R10: The interrupt output equals the flag ANDed with the interrupt-enable input, with no delay.
- R11: With the read strobe low, the status bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_en | input | 1 | Dot-clock enable; one dot per high cycle |
| render_en | input | 1 | Rendering enable; allows the odd-frame skip |
| nmi_en | input | 1 | Interrupt enable for the vertical-blank output |
| stat_rd | input | 1 | Status read strobe; clears the flag |
| stat_vbl | output | 1 | Status read data: the vertical-blank flag |
| nmi_o | output | 1 | Vertical-blank interrupt output |
| odd_frame | output | 1 | Frame parity bit |
| dot_cnt | output | DOT_W | Current dot within the line |
| line_cnt | output | LINE_W | Current scanline within the frame |

## Verification
The bench measures whole frames in dots. It checks odd frames with rendering on against frames without rendering. A design that skipped on the wrong parity, or that ignored the rendering input, would return a frame length off by one dot. A status read is placed exactly on the setting step. A design that let the set win over the read would then return 0 but raise the interrupt afterwards. The bench also reads twice in a row and holds the dot enable low. A flag that was not cleared by the read would show up on the second read, and counters that ignored the enable would show up while it is low.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   // Kind of move the raster position makes on a clock edge.
   typedef enum logic [1:0] {
      STEP_HOLD  = 2'd0,
      STEP_DOT   = 2'd1,
      STEP_LINE  = 2'd2,
      STEP_FRAME = 2'd3
   } rtg_step_e;
endpackage

// File: rtl/rtg_raster_counter.sv
module rtg_raster_counter
   import rtg_pkg::*;
#(
   parameter int DOTS     = 341,
   parameter int LINES    = 262,
   parameter int SKIP_DOT = 339,
   parameter bit ODD_SKIP = 1'b1,
   parameter int DOT_W    = $clog2(DOTS),
   parameter int LINE_W   = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dot_en,
   input  logic              render_en,
   output logic [DOT_W-1:0]  dot_q,
   output logic [LINE_W-1:0] line_q,
   output logic              odd_q
);
   localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(DOTS - 1);
   localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);
   localparam logic [DOT_W-1:0]  SKIP_POS  = DOT_W'(SKIP_DOT);

   logic      at_last_dot;
   logic      at_last_line;
   logic      skip_req;
   rtg_step_e step;

   assign at_last_dot  = (dot_q == LAST_DOT);
   assign at_last_line = (line_q == LAST_LINE);

   generate
      if (ODD_SKIP) begin : g_skip
         assign skip_req = dot_en & odd_q & render_en & at_last_line
                           & (dot_q == SKIP_POS);
      end else begin : g_noskip
         assign skip_req = 1'b0;
      end
   endgenerate

   always_comb begin
      step = STEP_HOLD;
      if (dot_en) begin
         if (skip_req)
            step = STEP_FRAME;
         else if (at_last_dot)
            step = at_last_line ? STEP_FRAME : STEP_LINE;
         else
            step = STEP_DOT;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dot_q  <= '0;
         line_q <= '0;
         odd_q  <= 1'b0;
      end else begin
         unique case (step)
            STEP_DOT: dot_q <= dot_q + DOT_W'(1);
            STEP_LINE: begin
               dot_q  <= '0;
               line_q <= line_q + LINE_W'(1);
            end
            STEP_FRAME: begin
               dot_q  <= '0;
               line_q <= '0;
               odd_q  <= ~odd_q;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rtg_vblank_flag.sv
module rtg_vblank_flag #(
   parameter int DOT_W    = 9,
   parameter int LINE_W   = 9,
   parameter int SET_LINE = 241,
   parameter int CLR_LINE = 261,
   parameter int FLAG_DOT = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dot_en,
   input  logic [DOT_W-1:0]  dot_q,
   input  logic [LINE_W-1:0] line_q,
   input  logic              stat_rd,
   input  logic              nmi_en,
   output logic              flag_q,
   output logic              stat_bit,
   output logic              nmi
);
   localparam logic [DOT_W-1:0]  FLAG_POS = DOT_W'(FLAG_DOT);
   localparam logic [LINE_W-1:0] SET_POS  = LINE_W'(SET_LINE);
   localparam logic [LINE_W-1:0] CLR_POS  = LINE_W'(CLR_LINE);

   logic on_flag_dot;
   logic set_hit;
   logic clr_hit;

   assign on_flag_dot = dot_en & (dot_q == FLAG_POS);
   assign set_hit     = on_flag_dot & (line_q == SET_POS);
   assign clr_hit     = on_flag_dot & (line_q == CLR_POS);

   // A read wins over the set event: the reader sees 0 and the flag stays low.
   always_ff @(posedge clk) begin
      if (rst)
         flag_q <= 1'b0;
      else if (stat_rd | clr_hit)
         flag_q <= 1'b0;
      else if (set_hit)
         flag_q <= 1'b1;
   end

   assign stat_bit = stat_rd & flag_q;
   assign nmi      = nmi_en & flag_q;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
   parameter int DOTS     = 341,
   parameter int LINES    = 262,
   parameter int SET_LINE = 241,
   parameter int CLR_LINE = 261,
   parameter int FLAG_DOT = 1,
   parameter int SKIP_DOT = 339,
   parameter bit ODD_SKIP = 1'b1,
   parameter int DOT_W    = $clog2(DOTS),
   parameter int LINE_W   = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dot_en,
   input  logic              render_en,
   input  logic              nmi_en,
   input  logic              stat_rd,
   output logic              stat_vbl,
   output logic              nmi_o,
   output logic              odd_frame,
   output logic [DOT_W-1:0]  dot_cnt,
   output logic [LINE_W-1:0] line_cnt
);
   generate
      if (DOTS < 4) begin : g_chk_dots
         $error("DOTS must be at least 4");
      end
      if (LINES < 2) begin : g_chk_lines
         $error("LINES must be at least 2");
      end
      if (SKIP_DOT < 1 || SKIP_DOT > DOTS - 2) begin : g_chk_skip
         $error("SKIP_DOT must lie in 1..DOTS-2");
      end
      if (FLAG_DOT >= DOTS) begin : g_chk_flag
         $error("FLAG_DOT must be below DOTS");
      end
      if (SET_LINE >= LINES || CLR_LINE >= LINES || SET_LINE == CLR_LINE) begin : g_chk_vlines
         $error("SET_LINE and CLR_LINE must be distinct lines of the frame");
      end
      if ((1 << DOT_W) < DOTS || (1 << LINE_W) < LINES) begin : g_chk_w
         $error("counter widths too narrow");
      end
   endgenerate

   logic vbl_flag;

   rtg_raster_counter #(
      .DOTS(DOTS), .LINES(LINES), .SKIP_DOT(SKIP_DOT),
      .ODD_SKIP(ODD_SKIP), .DOT_W(DOT_W), .LINE_W(LINE_W)
   ) i_counter (
      .clk(clk), .rst(rst), .dot_en(dot_en), .render_en(render_en),
      .dot_q(dot_cnt), .line_q(line_cnt), .odd_q(odd_frame)
   );

   rtg_vblank_flag #(
      .DOT_W(DOT_W), .LINE_W(LINE_W), .SET_LINE(SET_LINE),
      .CLR_LINE(CLR_LINE), .FLAG_DOT(FLAG_DOT)
   ) i_vblank (
      .clk(clk), .rst(rst), .dot_en(dot_en), .dot_q(dot_cnt),
      .line_q(line_cnt), .stat_rd(stat_rd), .nmi_en(nmi_en),
      .flag_q(vbl_flag), .stat_bit(stat_vbl), .nmi(nmi_o)
   );
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
   parameter int DOTS     = 341,
   parameter int LINES    = 262,
   parameter int SET_LINE = 241,
   parameter int CLR_LINE = 261,
   parameter int FLAG_DOT = 1,
   parameter int SKIP_DOT = 339,
   parameter bit ODD_SKIP = 1'b1,
   parameter int DOT_W    = 9,
   parameter int LINE_W   = 9
) (
   input logic              clk,
   input logic              rst,
   input logic              dot_en,
   input logic              render_en,
   input logic              nmi_en,
   input logic              stat_rd,
   input logic              stat_vbl,
   input logic              nmi_o,
   input logic              odd_frame,
   input logic [DOT_W-1:0]  dot_cnt,
   input logic [LINE_W-1:0] line_cnt,
   input logic              flag
);
   logic at_skip;
   logic skip_take;
   logic frame_end;

   assign at_skip   = dot_en && line_cnt == LINE_W'(LINES - 1)
                      && dot_cnt == DOT_W'(SKIP_DOT);
   assign skip_take = at_skip && ODD_SKIP && odd_frame && render_en;
   assign frame_end = skip_take || (dot_en && line_cnt == LINE_W'(LINES - 1)
                      && dot_cnt == DOT_W'(DOTS - 1));

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (dot_cnt == '0 && line_cnt == '0 && !odd_frame && !flag));     // R1
   AST_DOT_RANGE: assert property (@(posedge clk) disable iff (rst)
      dot_cnt <= DOT_W'(DOTS - 1));                                          // R2
   AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst)
      !dot_en |=> ($stable(dot_cnt) && $stable(line_cnt)));                  // R2
   AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (rst)
      frame_end |=> (odd_frame != $past(odd_frame)));                        // R3
   AST_PARITY_KEEP: assert property (@(posedge clk) disable iff (rst)
      !frame_end |=> $stable(odd_frame));                                    // R3
   AST_ODD_SKIP: assert property (@(posedge clk) disable iff (rst)
      skip_take |=> (dot_cnt == '0 && line_cnt == '0));                      // R4
   AST_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
      (at_skip && !skip_take) |=> (dot_cnt == DOT_W'(SKIP_DOT + 1)));        // R5
   AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
      (dot_en && !stat_rd && line_cnt == LINE_W'(SET_LINE)
       && dot_cnt == DOT_W'(FLAG_DOT)) |=> flag);                            // R6
   AST_FLAG_AUTOCLR: assert property (@(posedge clk) disable iff (rst)
      (dot_en && line_cnt == LINE_W'(CLR_LINE)
       && dot_cnt == DOT_W'(FLAG_DOT)) |=> !flag);                           // R7
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
      stat_rd |=> !flag);                                                    // R8
   AST_NMI_GATED: assert property (@(posedge clk) disable iff (rst)
      !nmi_en |-> !nmi_o);                                                   // R10
   AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (rst)
      !stat_rd |-> !stat_vbl);                                               // R11
endmodule

bind raster_timing_gen rtg_checker #(
   .DOTS(DOTS), .LINES(LINES), .SET_LINE(SET_LINE), .CLR_LINE(CLR_LINE),
   .FLAG_DOT(FLAG_DOT), .SKIP_DOT(SKIP_DOT), .ODD_SKIP(ODD_SKIP),
   .DOT_W(DOT_W), .LINE_W(LINE_W)
) i_rtg_checker (
   .clk(clk), .rst(rst), .dot_en(dot_en), .render_en(render_en),
   .nmi_en(nmi_en), .stat_rd(stat_rd), .stat_vbl(stat_vbl), .nmi_o(nmi_o),
   .odd_frame(odd_frame), .dot_cnt(dot_cnt), .line_cnt(line_cnt),
   .flag(vbl_flag)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
   localparam int DOTS     = 16;
   localparam int LINES    = 10;
   localparam int SET_LINE = 6;
   localparam int CLR_LINE = 9;
   localparam int FLAG_DOT = 1;
   localparam int SKIP_DOT = 14;
   localparam int DOT_W    = $clog2(DOTS);
   localparam int LINE_W   = $clog2(LINES);
   localparam int FULL     = DOTS * LINES;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              dot_en = 1'b0;
   logic              render_en = 1'b0;
   logic              nmi_en = 1'b0;
   logic              stat_rd = 1'b0;
   logic              stat_vbl;
   logic              nmi_o;
   logic              odd_frame;
   logic [DOT_W-1:0]  dot_cnt;
   logic [LINE_W-1:0] line_cnt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   raster_timing_gen #(
      .DOTS(DOTS), .LINES(LINES), .SET_LINE(SET_LINE), .CLR_LINE(CLR_LINE),
      .FLAG_DOT(FLAG_DOT), .SKIP_DOT(SKIP_DOT), .ODD_SKIP(1'b1)
   ) i_raster_timing_gen (
      .clk(clk), .rst(rst), .dot_en(dot_en), .render_en(render_en),
      .nmi_en(nmi_en), .stat_rd(stat_rd), .stat_vbl(stat_vbl), .nmi_o(nmi_o),
      .odd_frame(odd_frame), .dot_cnt(dot_cnt), .line_cnt(line_cnt)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // From one falling edge to the next: exactly one rising edge in between.
   task automatic clk1();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic adv(input int n);
      for (int i = 0; i < n; i++) clk1();
   endtask

   task automatic goto_origin();
      int guard = 0;
      while (!(dot_cnt == '0 && line_cnt == '0) && guard < 4 * FULL) begin
         clk1();
         guard++;
      end
   endtask

   task automatic run_frame(output int len);
      len = 0;
      do begin
         clk1();
         len++;
      end while (!(dot_cnt == '0 && line_cnt == '0) && len < 4 * FULL);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 dot after reset", int'(dot_cnt), 0);
      chk("R1 line after reset", int'(line_cnt), 0);
      chk("R1 parity after reset", int'(odd_frame), 0);
      nmi_en = 1'b1;
      #1 chk("R1 nmi after reset", int'(nmi_o), 0);
      nmi_en = 1'b0;
      dot_en = 1'b1;
      adv(37);
      rst = 1'b1;
      clk1();
      rst = 1'b0;
      chk("R1 dot after mid-run reset", int'(dot_cnt), 0);
      chk("R1 line after mid-run reset", int'(line_cnt), 0);
   endtask

   task automatic t_count_hold();
      adv(5);
      chk("R2 dot advances", int'(dot_cnt), 5);
      dot_en = 1'b0;
      adv(7);
      chk("R2 dot held with enable low", int'(dot_cnt), 5);
      chk("R2 line held with enable low", int'(line_cnt), 0);
      dot_en = 1'b1;
      adv(DOTS - 1 - 5);
      chk("R2 last dot of line", int'(dot_cnt), DOTS - 1);
      adv(1);
      chk("R2 dot wraps", int'(dot_cnt), 0);
      chk("R2 line advances", int'(line_cnt), 1);
      goto_origin();
   endtask

   task automatic t_frame(input bit ren, input string req);
      int len;
      int p0;
      render_en = ren;
      p0 = int'(odd_frame);
      run_frame(len);
      chk({req, " frame length"}, len, (p0 == 1 && ren) ? FULL - 1 : FULL);
      chk("R3 parity toggles at wrap", int'(odd_frame), 1 - p0);
   endtask

   task automatic t_vblank();
      nmi_en = 1'b1;
      adv(SET_LINE * DOTS + FLAG_DOT);
      chk("R6 flag clear before set dot", int'(nmi_o), 0);
      adv(1);
      chk("R6 flag set after set dot", int'(nmi_o), 1);
      chk("R11 status idle without read", int'(stat_vbl), 0);
      nmi_en = 1'b0;
      #1 chk("R10 nmi masked", int'(nmi_o), 0);
      nmi_en = 1'b1;
      #1 chk("R10 nmi unmasked", int'(nmi_o), 1);
      adv((CLR_LINE - SET_LINE) * DOTS - 1);
      chk("R7 flag still set before clear dot", int'(nmi_o), 1);
      adv(1);
      chk("R7 flag auto-cleared", int'(nmi_o), 0);
      goto_origin();
   endtask

   task automatic t_read();
      nmi_en = 1'b1;
      adv(SET_LINE * DOTS + FLAG_DOT + 3);
      stat_rd = 1'b1;
      #1 chk("R8 first read returns flag", int'(stat_vbl), 1);
      clk1();
      #1 chk("R8 second read returns 0", int'(stat_vbl), 0);
      stat_rd = 1'b0;
      #1 chk("R8 flag cleared by read", int'(nmi_o), 0);
      goto_origin();
   endtask

   task automatic t_race();
      int highs = 0;
      nmi_en = 1'b1;
      adv(SET_LINE * DOTS + FLAG_DOT);
      stat_rd = 1'b1;
      #1 chk("R9 read on set dot returns 0", int'(stat_vbl), 0);
      clk1();
      stat_rd = 1'b0;
      #1 chk("R9 flag not set after race", int'(nmi_o), 0);
      while (!(dot_cnt == '0 && line_cnt == '0)) begin
         clk1();
         if (nmi_o) highs++;
      end
      chk("R9 flag stays clear for frame", highs, 0);
      adv(SET_LINE * DOTS + FLAG_DOT + 1);
      chk("R6 flag sets again next frame", int'(nmi_o), 1);
      goto_origin();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_count_hold();
      t_frame(1'b1, "R4/R5 render on");
      t_frame(1'b1, "R4/R5 render on");
      t_frame(1'b0, "R5 render off");
      t_frame(1'b0, "R5 render off");
      t_vblank();
      t_read();
      t_race();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule